// File: doc/BRIEF.md
# Synchronous FIFO Controller with Read Replay

This block is a single-clock FIFO wrapped around an internal storage array. It serves one producer and one consumer. The read side presents data in one of two ways, and the choice is fixed when the block leaves reset. In request mode a read strobe moves the next stored word into the output register. In fall-through mode the oldest word appears in the output register without any strobe, and a read strobe tells the block that the word has been consumed.

Two status outputs are named by their meaning when high. `rdy_out` is high when data can be taken. `rdy_in` is high when a word can be accepted. In request mode `rdy_out` is therefore an active-low empty flag and `rdy_in` an active-low full flag. In fall-through mode they are the output-valid and input-space indications. A half-full output shows whether more than half of the array is occupied.

A consumer can save its current read position with `mark`. A later `retx` rewinds reading to that position so that a stretch of data can be replayed. While a mark is held, the words after it are protected from being overwritten.

Top module: `fifo_mark_ctrl`

## Requirements
- R1: While `mrst_n` is low at a clock edge, both pointers return to zero, any mark is dropped and `rd_data` becomes all zeros. After reset `rdy_out`=0, `rdy_in`=1 and `half_full`=0.
- R2: The level of `fwft_sel` at the reset edges selects fall-through mode (1) or request mode (0). Changing `fwft_sel` after reset has no effect until the next reset.
- R3: In request mode, `rdy_out` is 1 exactly when at least one word is stored. A read strobe with a stored word places the oldest word in `rd_data` at that clock edge, in write order.
- R4: In fall-through mode, a word written into an empty FIFO appears in `rd_data`, with `rdy_out` rising, one clock edge after the edge that wrote it. A read strobe while `rdy_out`=1 replaces `rd_data` with the next word at the same edge. If no further word is stored, `rdy_out` drops at that edge.
- R5: `rdy_in` is 0 exactly when no array location is free. In request mode the array holds DEPTH words. In fall-through mode the output register holds one word more.
- R6: `half_full` is 1 exactly when the number of stored words exceeds DEPTH/2. In fall-through mode the stored words include a valid word in the output register.
- R7: While `ld_en` is 0, write and read strobes have no effect.
- R8: A write while `rdy_in`=0 is dropped. A read strobe in request mode with nothing stored leaves `rd_data` unchanged.
- R9: `mark` saves the position of the word currently at the read position. In fall-through mode that is the word shown in `rd_data`. A `retx` while a mark is held makes reading resume from that word and recomputes the stored count. `retx` takes priority over a read strobe in the same cycle and releases the mark.
- R10: While a mark is held, free space is counted from the marked position, so words after the mark are never overwritten. A `retx` with no mark held is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| fwft_sel | input | 1 | Read-mode select, sampled during reset (1 = fall-through) |
| ld_en | input | 1 | Must be high for reads and writes to act |
| wr_en | input | 1 | Write strobe |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Read strobe (request mode) or consume strobe (fall-through) |
| mark | input | 1 | Save the current read position |
| retx | input | 1 | Rewind reading to the saved position |
| rd_data | output | W | Output data register |
| rdy_out | output | 1 | Not-empty (request) / output valid (fall-through) |
| rdy_in | output | 1 | Not-full (request) / input space (fall-through) |
| half_full | output | 1 | More than DEPTH/2 words stored |

## Verification
Every cycle, the embedded properties check the following. A write refused for lack of space or a cleared `ld_en` leaves the write position unchanged. The occupied span counted from the guard position never exceeds the array. A fall-through output register with a stored word behind it fills on the next edge. A replay reloads the read position from the saved mark. An empty request-mode read leaves the output alone. Data ordering, the half-full threshold, and the exact replayed word sequence after a mark, including the overwrite protection, are visible only through the bench's scenarios. Those scenarios compare each output word with its arithmetically generated write value.

// File: rtl/fifo_mark_ctrl.sv
module fifo_mark_ctrl #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic         clk,
  input  logic         mrst_n,
  input  logic         fwft_sel,
  input  logic         ld_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic         mark,
  input  logic         retx,
  output logic [W-1:0] rd_data,
  output logic         rdy_out,
  output logic         rdy_in,
  output logic         half_full
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, mark_ptr;
  logic          fwft_q, ov_q, mark_vld;

  logic [PW-1:0] mem_cnt, guard, used, head_pos;
  logic [PW:0]   stored;
  logic          space, has_word, do_wr, do_retx, std_rd, fw_take, fw_load, adv;

  assign mem_cnt  = wr_ptr - rd_ptr;
  assign guard    = mark_vld ? mark_ptr : rd_ptr;
  assign used     = wr_ptr - guard;
  assign space    = used < PW'(DEPTH);
  assign has_word = mem_cnt != '0;
  assign do_wr    = ld_en && wr_en && space;
  assign do_retx  = retx && mark_vld;
  assign std_rd   = !fwft_q && ld_en && rd_en && has_word && !do_retx;
  assign fw_take  = fwft_q && ld_en && rd_en && ov_q && !do_retx;
  assign fw_load  = fwft_q && !do_retx && has_word && (!ov_q || fw_take);
  assign adv      = std_rd || fw_load;
  assign head_pos = rd_ptr - PW'(fwft_q && ov_q);
  assign stored   = {1'b0, mem_cnt} + (PW+1)'(fwft_q && ov_q);

  assign rdy_out   = fwft_q ? ov_q : has_word;
  assign rdy_in    = space;
  assign half_full = stored > (PW+1)'(DEPTH / 2);

  always_ff @(posedge clk) begin
    if (do_wr && mrst_n) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      mark_ptr <= '0;
      mark_vld <= 1'b0;
      ov_q     <= 1'b0;
      rd_data  <= '0;
      fwft_q   <= fwft_sel;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_retx) begin
        rd_ptr   <= mark_ptr;
        mark_vld <= 1'b0;
        if (fwft_q) ov_q <= 1'b0;
      end else begin
        if (mark) begin
          mark_ptr <= head_pos;
          mark_vld <= 1'b1;
        end
        if (adv) begin
          rd_data <= mem[rd_ptr[AW-1:0]];
          rd_ptr  <= rd_ptr + 1'b1;
        end
        if (fw_load) ov_q <= 1'b1;
        else if (fw_take) ov_q <= 1'b0;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!mrst_n)
    (ld_en && wr_en && !rdy_in) |=> wr_ptr == $past(wr_ptr)); // R8
  AST_LD_GATES_WRITE: assert property (@(posedge clk) disable iff (!mrst_n)
    (!ld_en) |=> wr_ptr == $past(wr_ptr)); // R7
  AST_GUARD_SPAN: assert property (@(posedge clk) disable iff (!mrst_n)
    used <= PW'(DEPTH)); // R10
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!mrst_n)
    (!fwft_q && ld_en && rd_en && !rdy_out && !retx) |=> $stable(rd_data)); // R8
  AST_FWFT_FILL: assert property (@(posedge clk) disable iff (!mrst_n)
    (fwft_q && !ov_q && has_word && !retx) |=> ov_q); // R4
  AST_RETX_RELOAD: assert property (@(posedge clk) disable iff (!mrst_n)
    (retx && mark_vld) |=> rd_ptr == $past(mark_ptr)); // R9
endmodule

// File: tb/fifo_mark_ctrl_tb.sv
module fifo_mark_ctrl_tb;
  localparam int W = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic mrst_n = 1'b0, fwft_sel = 1'b0, ld_en = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, mark = 1'b0, retx = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic rdy_out, rdy_in, half_full;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  fifo_mark_ctrl #(.W(W), .AW(AW)) u_dut (
    .clk(clk), .mrst_n(mrst_n), .fwft_sel(fwft_sel), .ld_en(ld_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .mark(mark), .retx(retx),
    .rd_data(rd_data), .rdy_out(rdy_out), .rdy_in(rdy_in), .half_full(half_full));

  function automatic logic [W-1:0] pat(input int i);
    return W'((i * 29 + 7) & 8'hFF);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [W-1:0] d, input logic r,
                      input logic m, input logic x);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; mark = m; retx = x;
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0; mark = 0; retx = 0;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    mrst_n = 0; fwft_sel = mode;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    mrst_n = 1; fwft_sel = ~mode;
    #1;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // request mode
    do_reset(1'b0);
    chk("R1 rd_data zero", rd_data, 0);
    chk("R1 rdy_out", rdy_out, 0);
    chk("R1 rdy_in", rdy_in, 1);
    chk("R1 half_full", half_full, 0);
    ld_en = 0;
    step(1, pat(99), 0, 0, 0);
    chk("R7 write ignored", rdy_out, 0);
    ld_en = 1;
    for (int k = 1; k <= DEPTH; k++) begin
      step(1, pat(k - 1), 0, 0, 0);
      chk("R3 rdy_out fill", rdy_out, 1);
      chk("R5 rdy_in fill", rdy_in, (k < DEPTH) ? 1 : 0);
      chk("R6 half_full fill", half_full, (k > DEPTH / 2) ? 1 : 0);
    end
    step(1, pat(50), 0, 0, 0);
    chk("R8 full write dropped", rdy_in, 0);
    ld_en = 0;
    step(0, 0, 1, 0, 0);
    chk("R7 read ignored", rd_data, 0);
    ld_en = 1;
    for (int j = 0; j < DEPTH; j++) begin
      step(0, 0, 1, 0, 0);
      chk("R3 read order", rd_data, pat(j));
      chk("R3 rdy_out drain", rdy_out, (j < DEPTH - 1) ? 1 : 0);
      chk("R6 half_full drain", half_full, (DEPTH - 1 - j > DEPTH / 2) ? 1 : 0);
    end
    step(0, 0, 1, 0, 0);
    chk("R8 empty read hold", rd_data, pat(DEPTH - 1));

    // mark protection and replay in request mode
    do_reset(1'b0);
    for (int k = 0; k < DEPTH; k++) step(1, pat(k), 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R3 second word", rd_data, pat(1));
    step(0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R9 pre-replay word", rd_data, pat(3));
    step(1, pat(8), 0, 0, 0);
    chk("R10 space after one", rdy_in, 1);
    step(1, pat(9), 0, 0, 0);
    chk("R10 guarded full", rdy_in, 0);
    step(1, pat(10), 0, 0, 0);
    step(0, 0, 1, 0, 1);
    chk("R9 retx beats read", rd_data, pat(3));
    chk("R9 rdy_in after retx", rdy_in, 0);
    chk("R9 half_full after retx", half_full, 1);
    for (int j = 2; j < 10; j++) begin
      step(0, 0, 1, 0, 0);
      chk("R9 replay order", rd_data, pat(j));
    end
    chk("R10 drop after guard", rdy_out, 0);
    step(0, 0, 0, 0, 1);
    chk("R10 retx without mark", rdy_out, 0);

    // fall-through mode (fwft_sel flipped after reset)
    do_reset(1'b1);
    chk("R1 rdy_out fwft", rdy_out, 0);
    step(1, pat(0), 0, 0, 0);
    chk("R4 not yet visible", rdy_out, 0);
    step(0, 0, 0, 0, 0);
    chk("R2 R4 head visible", rdy_out, 1);
    chk("R4 head data", rd_data, pat(0));
    for (int k = 1; k <= DEPTH; k++) begin
      step(1, pat(k), 0, 0, 0);
      chk("R5 fwft rdy_in", rdy_in, (k < DEPTH) ? 1 : 0);
      chk("R6 fwft half_full", half_full, (k + 1 > DEPTH / 2) ? 1 : 0);
    end
    step(1, pat(60), 0, 0, 0);
    chk("R8 fwft full write dropped", rdy_in, 0);
    for (int j = 1; j <= DEPTH; j++) begin
      step(0, 0, 1, 0, 0);
      chk("R4 consume advance", rd_data, pat(j));
      chk("R4 rdy_out hold", rdy_out, 1);
    end
    step(0, 0, 1, 0, 0);
    chk("R4 last consumed", rdy_out, 0);

    for (int k = 30; k < 33; k++) step(1, pat(k), 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R4 head again", rd_data, pat(30));
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 0);
    chk("R4 next word", rd_data, pat(32));
    step(0, 0, 0, 0, 1);
    chk("R9 fwft retx clears valid", rdy_out, 0);
    step(0, 0, 0, 0, 0);
    chk("R9 fwft marked word", rd_data, pat(31));
    chk("R9 fwft valid again", rdy_out, 1);
    step(0, 0, 1, 0, 0);
    chk("R9 fwft replay next", rd_data, pat(32));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule